// File: doc/BRIEF.md
# Revolution-Harmonic Comb Notch Filter

This block takes a stream of signed position samples and strips out the DC offset together with every harmonic of a periodic revolution frequency. It works as a complementary estimator. A third-order IIR recursion, whose delay elements sit exactly one revolution (n samples) apart, tracks the slowly changing periodic part of the signal. The output is the live input minus that estimate. Because the recursion only ever looks at samples whole revolutions back, its response repeats at every multiple of the revolution frequency, and so the notches land at DC and at each harmonic.

The spaced history is held in dual-port RAM. Every accepted sample writes one row and reads the row written one revolution earlier in the same cycle. Software sets the seven coefficients and the revolution length n through a small write-only register port. Coefficients can be changed while samples keep flowing. A new n restarts the history, and the output stays at zero until three full revolutions have been collected.

Top module: `cnf_comb_notch`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and out_data is 0 until the first accepted sample.
- R2: Each cycle with in_valid high produces exactly one result with out_valid high on the next clock edge. out_valid is low in every other cycle.
- R3: The result is x[m] − y[m] saturated to the signed 16-bit range [−32768, 32767].
- R4: The estimate is y[m] = floor((b0·x[m] + Σ_{i=1..3} (b_i·x[m−i·n] − a_i·y[m−i·n])) / 2^14), saturated to signed 16 bits. It is computed in full precision with coefficients in signed Q2.14, and the saturated value is what later samples see as y.
- R5: After reset or after any write of n, history taps are read as zero: tap i counts only once at least i·n samples have been accepted. The result is forced to 0 for the first 3·n accepted samples.
- R6: Register map on cfg_addr: 0..3 select b0..b3, 4..6 select a1..a3, and 7 selects n (value in cfg_wdata). A coefficient write takes effect from the next accepted sample. A sample accepted in the same cycle still uses the old value, and the history is not disturbed.
- R7: A write of n = 0 acts as n = 1, and a value above MAX_N (1024) acts as MAX_N.
- R8: With b1 = 1.0 (16384) and all other coefficients zero, an input that repeats every n samples gives a result of 0 once warm-up is over.
- R9: Cycles without in_valid change neither the history nor the sample count, and out_data holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | 16 | Signed input sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (see R6) |
| cfg_wdata | input | 16 | Register write value |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 16 | Signed filtered result |

## Verification
The assertions rely on two assumptions about the inputs. First, a write of n is never issued in the same cycle as an accepted sample. Second, cfg_addr only carries meaning when cfg_we is high. The bench always places an n write in an idle cycle of its own. It lets coefficient writes coincide with samples, so that the rule that the old value still applies to that sample gets exercised. Random sample values, gaps and coefficient sets are bounded in magnitude so that the recursion stays mostly unsaturated. Directed cases then drive the output and estimate clamps on purpose.

// File: rtl/cnf_pkg.sv
`timescale 1ns/1ps
package cnf_pkg;
    localparam int SMP_W  = 16;
    localparam int COEF_W = 16;
    localparam int FRAC_W = 14;
    localparam int TAPS   = 3;
    localparam int PROD_W = SMP_W + COEF_W;
    localparam int ACC_W  = PROD_W + 4;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (SMP_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(-(2 ** (SMP_W - 1)));

    function automatic smp_t sat_smp(input logic signed [ACC_W-1:0] v);
        if (v > SAT_HI)      return {1'b0, {(SMP_W-1){1'b1}}};
        else if (v < SAT_LO) return {1'b1, {(SMP_W-1){1'b0}}};
        else                 return v[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/cnf_cfg_regs.sv
`timescale 1ns/1ps
module cnf_cfg_regs
    import cnf_pkg::*;
#(
    parameter int MAX_N = 1024,
    localparam int N_W  = $clog2(MAX_N + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [2:0]                   cfg_addr,
    input  logic [COEF_W-1:0]            cfg_wdata,
    output logic [TAPS:0][COEF_W-1:0]    b_o,
    output logic [TAPS-1:0][COEF_W-1:0]  a_o,
    output logic [N_W-1:0]               n_o,
    output logic                         n_load_o
);
    typedef struct packed {
        logic [TAPS:0][COEF_W-1:0]   b;
        logic [TAPS-1:0][COEF_W-1:0] a;
        logic [N_W-1:0]              n;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic n_sel;

    assign n_sel = cfg_we && (cfg_addr == 3'(2 * TAPS + 1));

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            for (int i = 0; i <= TAPS; i++)
                if (cfg_addr == 3'(i)) cfg_d.b[i] = cfg_wdata;
            for (int i = 0; i < TAPS; i++)
                if (cfg_addr == 3'(TAPS + 1 + i)) cfg_d.a[i] = cfg_wdata;
        end
        if (n_sel) begin
            if (cfg_wdata == '0)             cfg_d.n = N_W'(1);
            else if (int'(cfg_wdata) > MAX_N) cfg_d.n = N_W'(MAX_N);
            else                             cfg_d.n = cfg_wdata[N_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.b <= '0;
            cfg_q.a <= '0;
            cfg_q.n <= N_W'(MAX_N);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign b_o      = cfg_q.b;
    assign a_o      = cfg_q.a;
    assign n_o      = cfg_q.n;
    assign n_load_o = n_sel;
endmodule

// File: rtl/cnf_delay_bank.sv
`timescale 1ns/1ps
module cnf_delay_bank #(
    parameter int LANES = 6,
    parameter int WIDTH = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [AW-1:0]                addr,
    input  logic [LANES-1:0][WIDTH-1:0]  wdata,
    output logic [LANES-1:0][WIDTH-1:0]  rdata
);
    // One RAM per lane; the write port and the read port share the row
    // pointer, so a read returns what was written one revolution ago.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WIDTH-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en) mem[addr] <= wdata[g];
        end
        assign rdata[g] = mem[addr];
    end
endmodule

// File: rtl/cnf_estimator.sv
`timescale 1ns/1ps
module cnf_estimator
    import cnf_pkg::*;
(
    input  smp_t                         x_i,
    input  logic [TAPS-1:0][SMP_W-1:0]   xd_i,
    input  logic [TAPS-1:0][SMP_W-1:0]   yd_i,
    input  logic [TAPS:0][COEF_W-1:0]    b_i,
    input  logic [TAPS-1:0][COEF_W-1:0]  a_i,
    input  logic [TAPS-1:0]              tap_ok_i,
    output smp_t                         y_o
);
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        acc = ACC_W'($signed(b_i[0])) * ACC_W'(x_i);
        for (int i = 0; i < TAPS; i++) begin
            if (tap_ok_i[i]) begin
                acc = acc
                    + ACC_W'($signed(b_i[i+1])) * ACC_W'($signed(xd_i[i]))
                    - ACC_W'($signed(a_i[i]))   * ACC_W'($signed(yd_i[i]));
            end
        end
        y_o = sat_smp(acc >>> FRAC_W);
    end
endmodule

// File: rtl/cnf_comb_notch.sv
`timescale 1ns/1ps
module cnf_comb_notch
    import cnf_pkg::*;
#(
    parameter int MAX_N  = 1024,
    localparam int N_W   = $clog2(MAX_N + 1),
    localparam int AW    = $clog2(MAX_N),
    localparam int CW    = $clog2(TAPS * MAX_N + 1),
    localparam int LANES = 2 * TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SMP_W-1:0]  in_data,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [COEF_W-1:0] cfg_wdata,
    output logic              out_valid,
    output logic [SMP_W-1:0]  out_data
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic          out_valid;
        smp_t          out_data;
    } st_t;

    st_t st_d, st_q;

    logic [TAPS:0][COEF_W-1:0]   coef_b;
    logic [TAPS-1:0][COEF_W-1:0] coef_a;
    logic [N_W-1:0]              n_cur;
    logic                        n_load;
    logic [LANES-1:0][SMP_W-1:0] ram_wd, ram_rd;
    logic [TAPS-1:0][SMP_W-1:0]  x_dly, y_dly;
    logic [TAPS-1:0]             tap_ok;
    logic                        warm;
    smp_t                        x_cur, y_est;
    logic signed [ACC_W-1:0]     diff;

    assign x_cur = $signed(in_data);

    cnf_cfg_regs #(.MAX_N(MAX_N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .b_o(coef_b), .a_o(coef_a), .n_o(n_cur),
        .n_load_o(n_load)
    );

    cnf_delay_bank #(.LANES(LANES), .WIDTH(SMP_W), .DEPTH(MAX_N)) u_bank (
        .clk(clk), .wr_en(in_valid), .addr(st_q.ptr), .wdata(ram_wd),
        .rdata(ram_rd)
    );

    cnf_estimator u_est (
        .x_i(x_cur), .xd_i(x_dly), .yd_i(y_dly), .b_i(coef_b), .a_i(coef_a),
        .tap_ok_i(tap_ok), .y_o(y_est)
    );

    // Lane layout: 0..TAPS-1 input history, TAPS..2*TAPS-1 estimate history.
    // Each row shifts its taps one revolution further back when rewritten.
    always_comb begin
        for (int i = 0; i < TAPS; i++) begin
            x_dly[i] = ram_rd[i];
            y_dly[i] = ram_rd[TAPS+i];
        end
        ram_wd[0]    = in_data;
        ram_wd[TAPS] = y_est;
        for (int i = 1; i < TAPS; i++) begin
            ram_wd[i]      = ram_rd[i-1];
            ram_wd[TAPS+i] = ram_rd[TAPS+i-1];
        end
    end

    // History gating replaces a RAM sweep after an n change.
    always_comb begin
        for (int i = 0; i < TAPS; i++)
            tap_ok[i] = st_q.cnt >= CW'(i + 1) * CW'(n_cur);
        warm = st_q.cnt < CW'(TAPS) * CW'(n_cur);
    end

    assign diff = ACC_W'(x_cur) - ACC_W'(y_est);

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = in_valid;
        if (in_valid) begin
            st_d.out_data = warm ? '0 : sat_smp(diff);
            st_d.ptr      = (st_q.ptr == AW'(n_cur - N_W'(1))) ? '0 : st_q.ptr + AW'(1);
            if (warm) st_d.cnt = st_q.cnt + CW'(1);
        end
        if (n_load) begin
            st_d.ptr = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;
endmodule

// File: rtl/cnf_comb_notch_chk.sv
`timescale 1ns/1ps
module cnf_comb_notch_chk #(
    parameter int MAX_N = 1024,
    localparam int N_W  = $clog2(MAX_N + 1),
    localparam int CW   = $clog2(3 * MAX_N + 1)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        cfg_we,
    input logic [2:0]  cfg_addr,
    input logic [15:0] cfg_wdata,
    input logic        out_valid,
    input logic [15:0] out_data
);
    logic [N_W-1:0] seen_n;
    logic [CW-1:0]  seen_cnt;
    logic           seen_warm;

    assign seen_warm = seen_cnt < CW'(3) * CW'(seen_n);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_n   <= N_W'(MAX_N);
            seen_cnt <= '0;
        end else if (cfg_we && cfg_addr == 3'd7) begin
            seen_cnt <= '0;
            if (cfg_wdata == 16'd0)           seen_n <= N_W'(1);
            else if (int'(cfg_wdata) > MAX_N) seen_n <= N_W'(MAX_N);
            else                              seen_n <= cfg_wdata[N_W-1:0];
        end else if (in_valid && seen_warm) begin
            seen_cnt <= seen_cnt + CW'(1);
        end
    end

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    p_warm_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seen_warm) |=> (out_data == 16'd0));
endmodule

bind cnf_comb_notch cnf_comb_notch_chk #(.MAX_N(MAX_N)) u_chk (.*);

// File: tb/cnf_comb_notch_bench.sv
`timescale 1ns/1ps
module cnf_comb_notch_bench;
    localparam int MAX_N = 1024;
    localparam int HIST  = 4096;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_data;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        out_valid;
    logic [15:0] out_data;

    cnf_comb_notch #(.MAX_N(MAX_N)) u_cnf_comb_notch (.*);

    always #2.5 clk = ~clk;

    int total = 0, fails = 0;
    int n_m, m_m;
    int b_m[4];
    int a_m[3];
    int xh[HIST];
    int yh[HIST];
    bit pend_v = 0;
    int pend_exp = 0, held = 0;
    string pend_tag = "";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int model(input int x);
        longint acc;
        int y, r;
        acc = longint'(b_m[0]) * x;
        for (int i = 1; i <= 3; i++) begin
            if (m_m >= i * n_m) begin
                acc += longint'(b_m[i]) * xh[(m_m - i * n_m) % HIST];
                acc -= longint'(a_m[i-1]) * yh[(m_m - i * n_m) % HIST];
            end
        end
        y = sat16(acc >>> 14);
        r = (m_m < 3 * n_m) ? 0 : sat16(longint'(x) - y);
        xh[m_m % HIST] = x;
        yh[m_m % HIST] = y;
        m_m++;
        return r;
    endfunction

    function automatic void cfg_model(input int addr, input int data);
        int sd;
        sd = int'($signed(16'(data)));
        if (addr <= 3) b_m[addr] = sd;
        else if (addr <= 6) a_m[addr-4] = sd;
        else begin
            if (data == 0) n_m = 1;
            else if (data > MAX_N) n_m = MAX_N;
            else n_m = data;
            m_m = 0;
        end
    endfunction

    task automatic step(input bit v, input int x, input bit we, input int addr,
                        input int data, input string tag);
        @(negedge clk);
        if (pend_v) begin
            chk(out_valid === 1'b1, "R2", int'(out_valid), 1);
            chk(int'($signed(out_data)) == pend_exp, pend_tag,
                int'($signed(out_data)), pend_exp);
            held = pend_exp;
        end else begin
            chk(out_valid === 1'b0, "R2", int'(out_valid), 0);
            chk(int'($signed(out_data)) == held, "R9",
                int'($signed(out_data)), held);
        end
        in_valid  = v;
        in_data   = 16'(x);
        cfg_we    = we;
        cfg_addr  = 3'(addr);
        cfg_wdata = 16'(data);
        if (v) pend_exp = model(x);
        if (we) cfg_model(addr, data);
        pend_v   = v;
        pend_tag = tag;
    endtask

    task automatic wr(input int addr, input int data);
        step(0, 0, 1, addr, data, "R6");
    endtask

    task automatic sample(input int x, input string tag);
        step(1, x, 0, 0, 0, tag);
    endtask

    function automatic int rnd(input int lo, input int hi);
        return lo + int'($urandom % 32'(hi - lo + 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int pat[8];
        void'($urandom(32'd4242));
        n_m = MAX_N; m_m = 0;
        foreach (b_m[i]) b_m[i] = 0;
        foreach (a_m[i]) a_m[i] = 0;
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
        chk(out_data === 16'd0, "R1", int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0 && out_data === 16'd0, "R1", int'(out_data), 0);

        // R5: default n, zero coefficients, warm-up forces zero
        for (int i = 0; i < 5; i++) sample(rnd(-30000, 30000), "R5");

        // R8: comb with one-revolution subtraction on a periodic input
        wr(7, 8);
        wr(1, 16384);
        foreach (pat[i]) pat[i] = rnd(-20000, 20000);
        for (int i = 0; i < 64; i++) sample(pat[i % 8], (i < 24) ? "R5" : "R8");

        // R4 / R6 / R9: random coefficients, gaps and live coefficient writes
        wr(7, 5);
        for (int i = 0; i < 4; i++) wr(i, rnd(-6000, 6000));
        for (int i = 4; i < 7; i++) wr(i, rnd(-3000, 3000));
        for (int k = 0; k < 600; k++) begin
            int r;
            r = rnd(0, 99);
            if (r < 25) step(0, 0, 0, 0, 0, "R9");
            else if (r < 30) begin
                int ad;
                ad = rnd(0, 6);
                step(1, rnd(-12000, 12000), 1, ad,
                     (ad < 4) ? rnd(-6000, 6000) : rnd(-3000, 3000), "R6");
            end else sample(rnd(-12000, 12000), "R4");
        end

        // R3: b0 = -1.0 makes the result 2x, which clamps
        wr(7, 2);
        wr(0, -16384);
        for (int i = 1; i < 7; i++) wr(i, 0);
        for (int i = 0; i < 6; i++) sample(rnd(-100, 100), "R5");
        sample(32767, "R3");
        sample(-32768, "R3");
        sample(20000, "R3");
        sample(-20000, "R3");
        sample(100, "R3");

        // R7: n = 0 acts as 1, with a first-order recursion
        wr(0, 8192);
        wr(4, -8192);
        wr(7, 0);
        for (int i = 0; i < 40; i++) sample(rnd(-25000, 25000), "R7");

        // R7: oversize n clamps to MAX_N
        wr(0, 0);
        wr(4, 0);
        wr(1, 16384);
        wr(7, 5000);
        for (int i = 0; i < 3 * MAX_N + 20; i++)
            sample(rnd(-15000, 15000), (i < 3 * MAX_N) ? "R5" : "R7");

        step(0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule